// File: doc/BRIEF.md
# Interrupt Request Controller

This block gathers a parameterised group of maskable interrupt lines and one non-maskable line. It brings every line into the local clock domain and qualifies each one according to its own trigger mode. It then hands the processor a single request together with the index of the source that should be serviced first.

Each maskable line can be qualified in one of four ways:
- **Level:** the request follows the synchronized input.
- **Rising edge:** the rising transition is captured in a pending bit.
- **Falling edge:** the falling transition is captured in a pending bit.
- **Hybrid:** a rising edge counts only if the input then stays high for a programmable number of cycles.

The non-maskable line always uses the hybrid qualification. It bypasses the enable register.

Software reaches the block through a small word-wide register port. Reads are combinational and writes take effect on the clock edge. The processor retires the reported source with a one-cycle acknowledge. An acknowledge given while nothing is being requested sets a sticky spurious flag.

Top module: `irq_hub`

## Requirements
- R1: Every request line, including the non-maskable one, passes through a two-stage synchronizer. The raw status word at address 0 shows the synchronized maskable lines in bits N-1..0 and the non-maskable line in bit N. A change at the pins appears there two clock edges later.
- R2: A source whose 2-bit mode field is 00 (level) requests service for exactly as long as its synchronized input is high. It never sets its pending bit.
- R3: In mode 01 (rising edge), a low-to-high transition sets the source's pending bit. The bit stays set when the input falls, and is removed only by an acknowledge or by a clear write.
- R4: In an edge mode, an input that remains high after its edge raises no further event. It has to return low and make a new transition before the pending bit can be set again.
- R5: In mode 10 (falling edge), only a high-to-low transition sets the pending bit, and a rising transition has no effect.
- R6: Several edges arriving while a source is already pending merge into one pending bit, which a single acknowledge removes.
- R7: The enable register at address 2 (bit i = 1 enables source i, reset value 0) gates only the request. A disabled edge-mode source still collects its pending bit, and that source requests service as soon as it is enabled.
- R8: Among enabled active maskable sources, the lowest index wins. The index output is valid in the same cycle as the request and is 0 when no request is present.
- R9: The non-maskable line ignores the enable register. It is accepted only when a rising edge is followed by the line staying high for QUAL consecutive synchronized samples, counting the edge sample, and a shorter pulse is discarded. When pending (status bit N), it is reported as index N and ranks above every maskable source.
- R10: In mode 11 (hybrid), a maskable source uses the same edge-plus-duration qualification as the non-maskable line, with QUAL taken from address 5 (reset value 4).
- R11: An acknowledge clears the pending bit of the source being reported in that cycle. If a new qualifying edge for the same source arrives in that same cycle, the bit stays set.
- R12: Writing ones to address 4 clears the matching pending bits (bit N for the non-maskable source), and a pending bit reads back at address 1.
- R13: An acknowledge while the request output is low sets the spurious flag, which is bit 0 of address 6 and the spur_o output. Writing 1 to that bit clears it.
- R14: After reset the enable word, mode word (address 3, two bits per source, source i at bits 2i+1..2i), pending word, spurious flag and request are all 0, and QUAL reads 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_SRC | Maskable request lines, active high, asynchronous |
| nmi_i | input | 1 | Non-maskable request line, active high, asynchronous |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| ack_i | input | 1 | Processor acknowledge of the reported source |
| req_o | output | 1 | Interrupt request to the processor |
| idx_o | output | clog2(N_SRC+1) | Index of the reported source (N_SRC = non-maskable) |
| nmi_o | output | 1 | Reported source is the non-maskable one |
| spur_o | output | 1 | Sticky spurious-acknowledge flag |

## Verification
Single-cycle pulses on an edge-mode line separate latched from followed behaviour. A line held high across an acknowledge shows whether an edge retriggers without a new transition. Hybrid pulses of exactly QUAL and QUAL-1 samples bracket the acceptance boundary, and a bad comparator shifts it by one. Mixed level patterns and a pending non-maskable event together with a maskable request expose the ranking. An edge timed into the acknowledge cycle distinguishes set-wins from clear-wins merging.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    typedef enum logic [1:0] {
        TRIG_LEVEL  = 2'b00,
        TRIG_RISE   = 2'b01,
        TRIG_FALL   = 2'b10,
        TRIG_HYBRID = 2'b11
    } trig_mode_e;

    localparam int unsigned REG_AW = 3;

    localparam logic [REG_AW-1:0] A_RAW  = 3'd0;
    localparam logic [REG_AW-1:0] A_PEND = 3'd1;
    localparam logic [REG_AW-1:0] A_MASK = 3'd2;
    localparam logic [REG_AW-1:0] A_MODE = 3'd3;
    localparam logic [REG_AW-1:0] A_CLR  = 3'd4;
    localparam logic [REG_AW-1:0] A_QUAL = 3'd5;
    localparam logic [REG_AW-1:0] A_STAT = 3'd6;

endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= '0;
                else        chain_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irq_hub_trig.sv
module irq_hub_trig
    import irq_hub_pkg::*;
#(
    parameter int unsigned QW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sig_i,
    input  logic [1:0]    mode_i,
    input  logic [QW-1:0] qual_i,
    input  logic          clr_i,
    output logic          pend_o,
    output logic          active_o
);

    localparam int unsigned CW = QW + 1;

    typedef struct packed {
        logic          prev;
        logic          pend;
        logic          armed;
        logic [CW-1:0] cnt;
    } trig_st_t;

    trig_st_t   st_d, st_q;
    trig_mode_e mode;
    logic       rise, fall, counting, qual_hit, fire;
    logic [CW-1:0] run_cnt;

    always_comb begin
        mode     = trig_mode_e'(mode_i);
        rise     = sig_i & ~st_q.prev;
        fall     = ~sig_i & st_q.prev;
        // samples high since the last rising edge, edge sample included
        run_cnt  = rise ? CW'(1) : st_q.cnt + CW'(1);
        counting = rise | (st_q.armed & sig_i);
        qual_hit = counting && (run_cnt >= {1'b0, qual_i});

        unique case (mode)
            TRIG_LEVEL:  fire = 1'b0;
            TRIG_RISE:   fire = rise;
            TRIG_FALL:   fire = fall;
            TRIG_HYBRID: fire = qual_hit;
            default:     fire = 1'b0;
        endcase

        st_d      = st_q;
        st_d.prev = sig_i;
        if (mode == TRIG_HYBRID) begin
            st_d.armed = counting & ~qual_hit;
            st_d.cnt   = counting ? run_cnt : '0;
        end else begin
            st_d.armed = 1'b0;
            st_d.cnt   = '0;
        end
        // a fresh event wins over a clear in the same cycle
        st_d.pend = (st_q.pend & ~clr_i) | fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o   = st_q.pend;
    assign active_o = (mode == TRIG_LEVEL) ? sig_i : st_q.pend;

endmodule

// File: rtl/irq_hub_arb.sv
module irq_hub_arb #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 4
) (
    input  logic [N-1:0]  req_vec_i,
    input  logic          nmi_i,
    output logic          req_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        req_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_vec_i[i]) begin
                req_o = 1'b1;
                idx_o = IW'(i);
            end
        end
        if (nmi_i) begin
            req_o = 1'b1;
            idx_o = IW'(N);
        end
    end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned N_SRC       = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned QUAL_W      = 8,
    parameter int unsigned QUAL_RST    = 4,
    parameter int unsigned DW          = 32,
    localparam int unsigned IW         = $clog2(N_SRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_i,
    input  logic              nmi_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    input  logic              ack_i,
    output logic              req_o,
    output logic [IW-1:0]     idx_o,
    output logic              nmi_o,
    output logic              spur_o
);

    localparam int unsigned MODE_W = 2 * N_SRC;
    localparam int unsigned NL     = N_SRC + 1;
    localparam logic [IW-1:0] NMI_IDX = IW'(N_SRC);

    typedef struct packed {
        logic [N_SRC-1:0]  mask;
        logic [MODE_W-1:0] mode;
        logic [QUAL_W-1:0] qual;
        logic              spur;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NL-1:0]    sync_vec;
    logic [NL-1:0]    pend_vec;
    logic [NL-1:0]    clr_vec;
    logic [NL-1:0]    w1c_vec;
    logic [NL-1:0]    ack_vec;
    logic [N_SRC-1:0] trig_act;
    logic [N_SRC-1:0] act_vec;
    logic [N_SRC-1:0] mask_q;
    logic             ack_hit;
    logic             unused_nmi_act;
    logic             unused_wdata;

    assign mask_q       = regs_q.mask;
    assign unused_wdata = ^reg_wdata_i;

    irq_hub_sync #(
        .W      (NL),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({nmi_i, irq_i}),
        .q_o   (sync_vec)
    );

    assign w1c_vec = (reg_wr_i && reg_addr_i == A_CLR) ? reg_wdata_i[NL-1:0] : '0;
    assign ack_hit = ack_i & req_o;

    for (genvar i = 0; i < NL; i++) begin : g_ack
        assign ack_vec[i] = ack_hit && (idx_o == IW'(i));
    end

    assign clr_vec = w1c_vec | ack_vec;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        irq_hub_trig #(
            .QW (QUAL_W)
        ) u_trig (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig_i    (sync_vec[i]),
            .mode_i   (regs_q.mode[2*i +: 2]),
            .qual_i   (regs_q.qual),
            .clr_i    (clr_vec[i]),
            .pend_o   (pend_vec[i]),
            .active_o (trig_act[i])
        );
    end

    irq_hub_trig #(
        .QW (QUAL_W)
    ) u_nmi_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .sig_i    (sync_vec[N_SRC]),
        .mode_i   (TRIG_HYBRID),
        .qual_i   (regs_q.qual),
        .clr_i    (clr_vec[N_SRC]),
        .pend_o   (pend_vec[N_SRC]),
        .active_o (unused_nmi_act)
    );

    assign act_vec = trig_act & regs_q.mask;

    irq_hub_arb #(
        .N  (N_SRC),
        .IW (IW)
    ) u_arb (
        .req_vec_i (act_vec),
        .nmi_i     (pend_vec[N_SRC]),
        .req_o     (req_o),
        .idx_o     (idx_o)
    );

    assign nmi_o  = req_o && (idx_o == NMI_IDX);
    assign spur_o = regs_q.spur;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr_i) begin
            unique case (reg_addr_i)
                A_MASK:  regs_d.mask = reg_wdata_i[N_SRC-1:0];
                A_MODE:  regs_d.mode = reg_wdata_i[MODE_W-1:0];
                A_QUAL:  regs_d.qual = reg_wdata_i[QUAL_W-1:0];
                A_STAT:  if (reg_wdata_i[0]) regs_d.spur = 1'b0;
                default: ;
            endcase
        end
        if (ack_i && !req_o) regs_d.spur = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.qual <= QUAL_W'(QUAL_RST);
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (reg_addr_i)
            A_RAW:   reg_rdata_o = DW'(sync_vec);
            A_PEND:  reg_rdata_o = DW'(pend_vec);
            A_MASK:  reg_rdata_o = DW'(regs_q.mask);
            A_MODE:  reg_rdata_o = DW'(regs_q.mode);
            A_QUAL:  reg_rdata_o = DW'(regs_q.qual);
            A_STAT:  reg_rdata_o = DW'(regs_q.spur);
            default: reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic [IW-1:0] idx,
    input logic          ack,
    input logic          spur,
    input logic [N:0]    pend,
    input logic [N:0]    clr,
    input logic [N-1:0]  act,
    input logic [N-1:0]  mask
);

    localparam logic [IW-1:0] NMI_IDX = IW'(N);

    logic [N-1:0] sel_onehot;
    assign sel_onehot = N'(1) << idx;

    // R3: a pending bit only drops when a clear addressed it
    p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(pend) & ~$past(clr)) & ~pend) == '0));

    // R8: no request means index zero
    p_idle_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (idx == '0));

    // R8: no enabled active source below the reported one
    p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && idx != NMI_IDX) |-> ((act & (sel_onehot - N'(1))) == '0));

    // R7: a maskable source is reported only when enabled
    p_mask_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && idx != NMI_IDX) |-> ((sel_onehot & mask) != '0));

    // R9: a pending non-maskable event is always the one reported
    p_nmi_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend[N] |-> (req && idx == NMI_IDX));

    // R13: acknowledge with no request raises the flag
    p_spur_set_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req) |=> spur);

endmodule

bind irq_hub irq_hub_chk #(
    .N  (N_SRC),
    .IW (IW)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_o),
    .idx   (idx_o),
    .ack   (ack_i),
    .spur  (spur_o),
    .pend  (pend_vec),
    .clr   (clr_vec),
    .act   (act_vec),
    .mask  (mask_q)
);

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb;
    import irq_hub_pkg::*;

    localparam int unsigned N  = 8;
    localparam int unsigned IW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq = '0;
    logic          nmi = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          ack = 1'b0;
    logic          req;
    logic [IW-1:0] idx;
    logic          nmi_rep;
    logic          spur;

    always #2 clk = ~clk;   // 250 MHz

    irq_hub u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq),
        .nmi_i       (nmi),
        .reg_addr_i  (reg_addr),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .ack_i       (ack),
        .req_o       (req),
        .idx_o       (idx),
        .nmi_o       (nmi_rep),
        .spur_o      (spur)
    );

    // scoreboard: kind 0 = {req,nmi,idx}, kind 1 = register read
    int          q_kind[$];
    logic [2:0]  q_addr[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_req(logic r, logic n, int unsigned i, string tag);
        q_kind.push_back(0);
        q_addr.push_back(3'd0);
        q_exp.push_back({22'd0, r, n, 8'(i)});
        q_tag.push_back(tag);
    endtask

    task automatic exp_rd(logic [2:0] a, logic [31:0] v, string tag);
        q_kind.push_back(1);
        q_addr.push_back(a);
        q_exp.push_back(v);
        q_tag.push_back(tag);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic pulse(int unsigned s, int n);
        irq[s] = 1'b1;
        tick(n);
        irq[s] = 1'b0;
    endtask

    task automatic nmi_pulse(int n);
        nmi = 1'b1;
        tick(n);
        nmi = 1'b0;
    endtask

    // monitor: pops expectations shortly after each falling edge
    initial begin
        int          k;
        logic [2:0]  a;
        logic [2:0]  saved;
        logic [31:0] e;
        logic [31:0] got;
        string       t;
        forever begin
            @(negedge clk);
            #0.5;
            saved = reg_addr;
            while (q_kind.size() > 0) begin
                k = q_kind.pop_front();
                a = q_addr.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (k == 0) begin
                    got = {22'd0, req, nmi_rep, 8'(idx)};
                end else begin
                    reg_addr = a;
                    #0.1;
                    got = reg_rdata;
                end
                n_chk++;
                if (got !== e) begin
                    n_fail++;
                    $display("FAIL %s: got 0x%0h expected 0x%0h", t, got, e);
                end
            end
            reg_addr = saved;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R14 reset state
        exp_rd(A_MASK, 32'h0, "R14 mask");
        exp_rd(A_MODE, 32'h0, "R14 mode");
        exp_rd(A_PEND, 32'h0, "R14 pend");
        exp_rd(A_QUAL, 32'd4, "R14 qual");
        exp_rd(A_STAT, 32'h0, "R14 spur");
        exp_req(0, 0, 0, "R14 req");
        tick(1);

        // R1 two-edge synchronizer latency on raw status
        irq = 8'h05;
        tick(1);
        exp_rd(A_RAW, 32'h0, "R1 raw after one edge");
        tick(1);
        exp_rd(A_RAW, 32'h05, "R1 raw after two edges");
        irq = '0;
        tick(3);

        // R2 level mode follows the input
        wr(A_MASK, 32'hFF);
        irq[3] = 1'b1;
        tick(1);
        exp_req(0, 0, 0, "R2 level not yet");
        tick(1);
        exp_req(1, 0, 3, "R2 level request");
        exp_rd(A_PEND, 32'h0, "R2 level no pending");
        irq[3] = 1'b0;
        tick(2);
        exp_req(0, 0, 0, "R2 level drop");

        // R8 lowest index wins
        irq = 8'hA4;
        tick(2);
        exp_req(1, 0, 2, "R8 lowest of 2,5,7");
        irq[2] = 1'b0;
        tick(2);
        exp_req(1, 0, 5, "R8 next lowest");
        irq = '0;
        tick(3);

        // modes: src1 rising, src4 falling, src6 hybrid
        wr(A_MODE, 32'h0000_3204);

        // R3 rising edge latches
        pulse(1, 1);
        tick(3);
        exp_rd(A_PEND, 32'h02, "R3 pending after pulse");
        exp_req(1, 0, 1, "R3 request from latch");

        // R11 acknowledge clears reported source
        do_ack();
        exp_rd(A_PEND, 32'h0, "R11 ack clears");
        exp_req(0, 0, 0, "R11 no request after ack");

        // R4 held-high input does not retrigger
        irq[1] = 1'b1;
        tick(4);
        exp_rd(A_PEND, 32'h02, "R4 first edge");
        do_ack();
        tick(4);
        exp_rd(A_PEND, 32'h0, "R4 held high no retrigger");
        irq[1] = 1'b0;
        tick(3);
        irq[1] = 1'b1;
        tick(4);
        exp_rd(A_PEND, 32'h02, "R4 new transition retriggers");

        // R12 write-one-to-clear
        wr(A_CLR, 32'h02);
        exp_rd(A_PEND, 32'h0, "R12 clear write");
        irq[1] = 1'b0;
        tick(3);

        // R6 merged events
        for (int p = 0; p < 3; p++) begin
            pulse(1, 1);
            tick(1);
        end
        tick(3);
        exp_rd(A_PEND, 32'h02, "R6 merged pending");
        do_ack();
        tick(2);
        exp_rd(A_PEND, 32'h0, "R6 one ack clears all");
        exp_req(0, 0, 0, "R6 no request left");

        // R5 falling edge only
        irq[4] = 1'b1;
        tick(4);
        exp_rd(A_PEND, 32'h0, "R5 rising ignored");
        irq[4] = 1'b0;
        tick(4);
        exp_rd(A_PEND, 32'h10, "R5 falling latched");
        exp_req(1, 0, 4, "R5 request");
        wr(A_CLR, 32'h10);
        exp_rd(A_PEND, 32'h0, "R12 clear src4");

        // R7 masked source keeps pending
        wr(A_MASK, 32'hFD);
        pulse(1, 1);
        tick(4);
        exp_rd(A_PEND, 32'h02, "R7 pending while masked");
        exp_req(0, 0, 0, "R7 masked no request");
        wr(A_MASK, 32'hFF);
        exp_req(1, 0, 1, "R7 request after unmask");
        wr(A_CLR, 32'h02);
        exp_req(0, 0, 0, "R7 cleared");

        // R10 hybrid maskable: QUAL-1 rejected, QUAL accepted
        pulse(6, 3);
        tick(6);
        exp_rd(A_PEND, 32'h0, "R10 short pulse rejected");
        exp_req(0, 0, 0, "R10 no request");
        pulse(6, 4);
        tick(4);
        exp_rd(A_PEND, 32'h40, "R10 qualified pulse");
        exp_req(1, 0, 6, "R10 request");
        wr(A_CLR, 32'h40);

        // R9 non-maskable, mask all off
        wr(A_MASK, 32'h00);
        nmi_pulse(3);
        tick(6);
        exp_rd(A_PEND, 32'h0, "R9 short nmi rejected");
        exp_req(0, 0, 0, "R9 no request");
        nmi_pulse(4);
        tick(4);
        exp_rd(A_PEND, 32'h100, "R9 nmi pending");
        exp_req(1, 1, 8, "R9 nmi ignores mask");
        wr(A_MASK, 32'h01);
        irq[0] = 1'b1;
        tick(3);
        exp_req(1, 1, 8, "R9 nmi above source 0");
        do_ack();
        exp_req(1, 0, 0, "R9 source 0 after nmi ack");
        exp_rd(A_PEND, 32'h0, "R9 nmi cleared");
        irq[0] = 1'b0;
        tick(3);
        exp_req(0, 0, 0, "R9 idle");
        wr(A_MASK, 32'hFF);

        // R11 new edge in the acknowledge cycle keeps the bit
        pulse(1, 1);
        tick(4);
        exp_rd(A_PEND, 32'h02, "R11 pending before race");
        irq[1] = 1'b1;
        tick(2);
        do_ack();
        tick(1);
        exp_rd(A_PEND, 32'h02, "R11 edge wins over ack");
        irq[1] = 1'b0;
        wr(A_CLR, 32'h02);
        exp_rd(A_PEND, 32'h0, "R12 clear after race");
        tick(3);

        // R13 spurious acknowledge
        exp_req(0, 0, 0, "R13 idle before ack");
        exp_rd(A_STAT, 32'h0, "R13 flag clear");
        tick(1);
        do_ack();
        exp_rd(A_STAT, 32'h1, "R13 flag set");
        wr(A_STAT, 32'h1);
        exp_rd(A_STAT, 32'h0, "R13 flag cleared");

        tick(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule